// File: doc/BRIEF.md
# Clocked Serial Port with Chip-Select Abort

This block moves one byte at a time over a three-wire synchronous link. The byte held in the data register leaves on the data-out pin, most significant bit first. The byte coming in on the data-in pin replaces it. The shift clock comes from one of two sources, chosen at run time. It is either divided down from the system clock and driven out, or taken from an external clock pin. When an external clock pin is used, that input is synchronized and its edges are detected internally.

An optional active-low chip-select input can be checked. With checking enabled, a started transfer first waits for chip-select to go low. A high level on chip-select during the shift aborts the transfer at once. After an abort both output pins are released to high impedance, and they stay released until software clears the abort flag.

Software works through a small register port with three registers: control, status and data. It reads the status register to tell the error causes apart: abort, overrun, or an access made while the unit was busy. Transfer completion and abort raise a single shared interrupt request, which is gated by an enable bit.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the control, status and data registers read 0, `irq` is 0, `sck_o` is 1, and both `so_oe` and `sck_oe` are 1.
- R2: The registers sit at these addresses:
  - Address 0 is control: bit0 selects the external clock, bit1 enables chip-select checking, bit2 enables the interrupt.
  - Address 1 is status: bit0 start/busy, bit1 interrupt flag, bit2 abort, bit3 overrun, bit4 wait-error.
  - Address 2 is data.
  - `rdata` is combinational on `addr`.
- R3: Writing 1 to status bit0 while idle, with abort clear, starts a transfer. The data register goes out MSB first. `so_o` changes only after a falling shift-clock edge, and `si_i` is sampled on rising edges. After the 8th rising edge busy clears, the data register holds the received byte, and the interrupt flag is set.
- R4: With the internal clock selected, `sck_o` idles high, `sck_oe` is 1, and each half period of the shift clock lasts HALF_DIV system clocks. With the external clock selected, `sck_oe` is 0.
- R5: With the external clock selected, edges on `sck_i` while no transfer is running have no effect on the shift state. A transfer started before the clock arrives completes normally.
- R6: A data-register read while busy (shifting, or waiting for chip-select) returns 0xFF and sets the wait-error flag.
- R7: A data-register write while busy leaves the data register unchanged and sets the wait-error flag.
- R8: With checking enabled, a started transfer stays busy and produces no shift-clock edges until `cs_n_i` is low. A high `cs_n_i` during shifting stops the transfer: busy goes to 0, and abort and the interrupt flag go to 1.
- R9: While the abort flag is 1, `so_oe` and `sck_oe` are 0.
- R10: A start request has no effect while the abort flag is 1. The check uses the flag value before the write.
- R11: A transfer that completes while the previous received byte is still unread sets the overrun flag. A data read while idle marks the byte as read.
- R12: Status flags bit1 to bit4 clear when 0 is written to them, and writing 1 leaves them unchanged. A set event in the same cycle takes priority.
- R13: `irq` is high exactly when both the interrupt flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq | output | 1 | Shared interrupt request |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Output enable for sck_o |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so_o |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low chip-select |

## Verification
The bench toggles the external clock while the unit is idle, then checks that the pending MSB on the data-out pin has not moved. A design that counted those edges would shift early and corrupt the next byte. It makes data-register accesses while the unit is waiting for chip-select. A design that treated waiting as idle would return the real buffer or accept the write.

The bench aborts a transfer midway and tries to restart it with the abort flag still set. A design that let the restart through, or kept driving its pins, would show busy or a high output enable. Two back-to-back transfers without a read check that overrun depends on the unread byte and not on every completion.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_CS = 2'd1,
    ST_XFER    = 2'd2
  } xfer_state_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int B_BUSY = 0;
  localparam int B_IRQ  = 1;
  localparam int B_ABT  = 2;
  localparam int B_OVR  = 3;
  localparam int B_WAIT = 4;

  localparam int C_EXT  = 0;
  localparam int C_CSEN = 1;
  localparam int C_IEN  = 2;

  // write-zero-to-clear flag update, set event wins
  function automatic logic sticky_next(logic cur, logic keep, logic set_ev);
    return (cur & keep) | set_ev;
  endfunction

  // shift toward MSB, new bit enters at LSB
  function automatic logic [DW-1:0] shift_in(logic [DW-1:0] v, logic b);
    return {v[DW-2:0], b};
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;
  logic [N-1:0] chain_q;

  generate
    if (N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {N{RST_VAL}};
        else        chain_q <= {chain_q[N-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[N-1];
endmodule

// File: rtl/ssp_sckgen.sv
module ssp_sckgen #(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic sck_ext,
  output logic sck_int,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q;
  logic          tick;
  logic          ext_s, ext_prev_q;
  logic          int_rise, int_fall, ext_rise, ext_fall;

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sck_ext),
    .q     (ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= ext_s;
  end

  assign tick = run && !ext_sel && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      sck_int <= 1'b1;
    end else if (!run || ext_sel) begin
      div_q   <= '0;
      sck_int <= 1'b1;
    end else if (tick) begin
      div_q   <= '0;
      sck_int <= ~sck_int;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  assign int_rise = tick && !sck_int;
  assign int_fall = tick && sck_int;
  assign ext_rise = run && ext_s && !ext_prev_q;
  assign ext_fall = run && !ext_s && ext_prev_q;

  assign rise_ev = ext_sel ? ext_rise : int_rise;
  assign fall_ev = ext_sel ? ext_fall : int_fall;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         si,
  output logic         so,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int CNTW = $clog2(W + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(W - 1);

  logic [W-1:0]    sh_q;
  logic            samp_q;
  logic [CNTW-1:0] cnt_q;

  assign done = rise_ev && (cnt_q == CNT_LAST);
  assign rx   = shift_in(sh_q, si);
  assign so   = sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      sh_q   <= load_val;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (rise_ev) begin
        samp_q <= si;
        cnt_q  <= done ? '0 : cnt_q + 1'b1;
      end
      // the leading falling edge precedes any sample and shifts nothing
      if (fall_ev && (cnt_q != '0)) sh_q <= shift_in(sh_q, samp_q);
    end
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       so_o,
  output logic       so_oe,
  input  logic       si_i,
  input  logic       cs_n_i
);
  xfer_state_t st_q;
  logic [2:0]    ctrl_q;
  logic [DW-1:0] buf_q;
  logic          irq_flag_q, abt_q, ovr_q, wait_q, unread_q;

  logic ext_clk, cs_en, irq_en;
  logic busy, waiting, running;
  logic data_rd, data_wr, stat_wr, start_wr, start_ok;
  logic blocked_acc, abort_ev, xfer_done;
  logic cs_hi, si_s, sck_int, rise_ev, fall_ev, sh_done, sh_so;
  logic [DW-1:0] rx_byte;
  logic keep_irq, keep_abt, keep_ovr, keep_wait;

  assign ext_clk = ctrl_q[C_EXT];
  assign cs_en   = ctrl_q[C_CSEN];
  assign irq_en  = ctrl_q[C_IEN];

  assign busy    = (st_q != ST_IDLE);
  assign waiting = (st_q == ST_WAIT_CS);
  assign running = (st_q == ST_XFER);

  assign data_rd  = rd_en && (addr == A_DATA);
  assign data_wr  = wr_en && (addr == A_DATA);
  assign stat_wr  = wr_en && (addr == A_STAT);
  assign start_wr = stat_wr && wdata[B_BUSY];
  assign start_ok = start_wr && !busy && !abt_q;

  assign blocked_acc = busy && (data_rd || data_wr);
  assign abort_ev    = running && cs_en && cs_hi;
  assign xfer_done   = running && sh_done && !abort_ev;

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk (clk), .rst_n (rst_n), .d (cs_n_i), .q (cs_hi)
  );

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync (
    .clk (clk), .rst_n (rst_n), .d (si_i), .q (si_s)
  );

  ssp_sckgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_sckgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .ext_sel (ext_clk),
    .sck_ext (sck_i),
    .sck_int (sck_int),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  ssp_shifter #(.W(DW)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok || (data_wr && !busy)),
    .load_val (start_ok ? buf_q : wdata),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .si       (si_s),
    .so       (sh_so),
    .done     (sh_done),
    .rx       (rx_byte)
  );

  assign keep_irq  = !stat_wr || wdata[B_IRQ];
  assign keep_abt  = !stat_wr || wdata[B_ABT];
  assign keep_ovr  = !stat_wr || wdata[B_OVR];
  assign keep_wait = !stat_wr || wdata[B_WAIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (start_ok) st_q <= cs_en ? ST_WAIT_CS : ST_XFER;
        ST_WAIT_CS: if (!cs_hi)   st_q <= ST_XFER;
        ST_XFER:    if (abort_ev || xfer_done) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      buf_q      <= '0;
      irq_flag_q <= 1'b0;
      abt_q      <= 1'b0;
      ovr_q      <= 1'b0;
      wait_q     <= 1'b0;
      unread_q   <= 1'b0;
    end else begin
      if (wr_en && (addr == A_CTRL)) ctrl_q <= wdata[2:0];

      if (xfer_done)             buf_q <= rx_byte;
      else if (data_wr && !busy) buf_q <= wdata;

      if (xfer_done)             unread_q <= 1'b1;
      else if (data_rd && !busy) unread_q <= 1'b0;

      irq_flag_q <= sticky_next(irq_flag_q, keep_irq, abort_ev || xfer_done);
      abt_q      <= sticky_next(abt_q, keep_abt, abort_ev);
      ovr_q      <= sticky_next(ovr_q, keep_ovr, xfer_done && unread_q);
      wait_q     <= sticky_next(wait_q, keep_wait, blocked_acc);
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {5'b0, ctrl_q};
      A_STAT:  rdata = {3'b0, wait_q, ovr_q, abt_q, irq_flag_q, busy};
      A_DATA:  rdata = busy ? 8'hFF : buf_q;
      default: rdata = 8'h00;
    endcase
  end

  assign sck_o  = sck_int;
  assign sck_oe = !ext_clk && !abt_q;
  assign so_o   = sh_so;
  assign so_oe  = !abt_q;
  assign irq    = irq_flag_q && irq_en;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk
  import ssp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       waiting,
  input logic       abt_q,
  input logic       irq_flag_q,
  input logic       wait_q,
  input logic       so_oe,
  input logic       sck_oe,
  input logic       sck_o,
  input logic       start_wr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] buf_q,
  input logic       xfer_done
);
  // R8
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abt_q) |-> (!busy && irq_flag_q));

  // R9
  pins_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abt_q |-> (!so_oe && !sck_oe));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_q && start_wr) |=> !busy);

  // R6
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && addr == A_DATA) |-> (rdata == 8'hFF));

  // R6
  wait_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (rd_en || wr_en) && addr == A_DATA) |=> wait_q);

  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == A_DATA && !xfer_done) |=> $stable(buf_q));

  // R8
  cs_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> $stable(sck_o));
endmodule

bind sync_shift_port ssp_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .waiting    (waiting),
  .abt_q      (abt_q),
  .irq_flag_q (irq_flag_q),
  .wait_q     (wait_q),
  .so_oe      (so_oe),
  .sck_oe     (sck_oe),
  .sck_o      (sck_o),
  .start_wr   (start_wr),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .rdata      (rdata),
  .buf_q      (buf_q),
  .xfer_done  (xfer_done)
);

// File: tb/sync_shift_port_tb_top.sv
module sync_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;
  localparam int NVEC = 4;
  // {byte sent by the port, byte returned by the far end}
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, sck_o, sck_oe, so_o, so_oe;
  logic sck_i = 1'b1, si_i = 1'b0, cs_n_i = 1'b0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port #(.HALF_DIV(HALF), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe), .si_i(si_i), .cs_n_i(cs_n_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // far end for the internally clocked mode
  task automatic run_int(input logic [7:0] sb, output logic [7:0] cap, output int half);
    logic prev;
    int k, tf;
    k = 0; tf = -1; half = 0; cap = '0; si_i = sb[7]; prev = sck_o;
    for (int t = 0; t < 400 && k < 8; t++) begin
      @(negedge clk);
      if (!prev && sck_o) begin
        cap = {cap[6:0], so_o}; k++;
        if (k == 1 && tf >= 0) half = t - tf;
      end else if (prev && !sck_o) begin
        if (tf < 0) tf = t;
        if (k < 8) si_i = sb[7-k];
      end
      prev = sck_o;
    end
    repeat (3) @(negedge clk);
  endtask

  // far end that also supplies the clock
  task automatic run_ext(input logic [7:0] sb, output logic [7:0] cap);
    cap = '0;
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0; si_i = sb[7-k];
      repeat (6) @(negedge clk);
      cap = {cap[6:0], so_o};
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, cap;
    int half;
    logic all_high;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 reset state
    rd(AC, d); chk("R1 ctrl", d, 8'h00);
    rd(AS, d); chk("R1 stat", d, 8'h00);
    rd(AD, d); chk("R1 data", d, 8'h00);
    chk("R1 pins", {irq, sck_o, sck_oe, so_oe}, 4'b0111);

    // R3 R4 vector walk, internal clock
    for (int i = 0; i < NVEC; i++) begin
      wr(AD, VEC[i][15:8]);
      wr(AS, 8'h01);
      run_int(VEC[i][7:0], cap, half);
      chk("R3 sent", cap, VEC[i][15:8]);
      rd(AD, d); chk("R3 received", d, VEC[i][7:0]);
      rd(AS, d); chk("R3 status", d, 8'h02);
      if (i == 0) begin
        chk("R4 half period", half, HALF);
        chk("R13 irq gated off", irq, 1'b0);
      end
    end

    // R5 external clock, idle edges ignored
    wr(AC, 8'h01);
    chk("R4 ext sck_oe", sck_oe, 1'b0);
    wr(AD, 8'hA5);
    si_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      sck_i = 1'b0; repeat (6) @(negedge clk);
      sck_i = 1'b1; repeat (6) @(negedge clk);
    end
    chk("R5 so held while idle", so_o, 1'b1);
    wr(AS, 8'h01);
    run_ext(8'h96, cap);
    chk("R5 ext sent", cap, 8'hA5);
    rd(AD, d); chk("R5 ext received", d, 8'h96);

    // R11 overrun
    wr(AC, 8'h00);
    wr(AS, 8'h01); run_int(8'h11, cap, half);
    wr(AS, 8'h03); run_int(8'h22, cap, half);
    rd(AS, d); chk("R11 overrun set", d, 8'h0A);
    rd(AD, d); chk("R11 latest byte", d, 8'h22);
    wr(AS, 8'h01); run_int(8'h33, cap, half);
    rd(AS, d); chk("R11 no overrun after read", d, 8'h02);
    rd(AD, d);

    // R6 R7 R8 waiting and abort
    wr(AC, 8'h06);
    cs_n_i = 1'b1;
    wr(AD, 8'hC3);
    wr(AS, 8'h01);
    all_high = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!sck_o) all_high = 1'b0;
    end
    chk("R8 no clock while waiting", all_high, 1'b1);
    rd(AS, d); chk("R8 busy while waiting", d, 8'h01);
    rd(AD, d); chk("R6 blocked read", d, 8'hFF);
    wr(AD, 8'h33);
    rd(AS, d); chk("R6 wait flag", d, 8'h11);
    cs_n_i = 1'b0;
    repeat (20) @(negedge clk);
    cs_n_i = 1'b1;
    repeat (6) @(negedge clk);
    rd(AS, d); chk("R8 abort status", d, 8'h16);
    chk("R13 irq raised", irq, 1'b1);
    chk("R9 pins float", {so_oe, sck_oe}, 2'b00);
    cs_n_i = 1'b0;
    wr(AS, 8'h17);
    repeat (3) @(negedge clk);
    rd(AS, d); chk("R10 start refused and R12 ones keep", d, 8'h16);
    wr(AS, 8'h00);
    rd(AS, d); chk("R12 cleared", d, 8'h00);
    chk("R9 pins driven again", {so_oe, sck_oe}, 2'b11);
    chk("R13 irq low", irq, 1'b0);
    rd(AD, d); chk("R7 blocked write", d, 8'hC3);
    wr(AS, 8'h01);
    run_int(8'h5A, cap, half);
    chk("R8 sent with cs low", cap, 8'hC3);
    rd(AD, d); chk("R8 received with cs low", d, 8'h5A);
    chk("R13 irq after completion", irq, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule